// File: doc/BRIEF.md
# Second-Order Demultiplexer with Justification Removal

This block sits on the receive side of a second-order plesiochronous link. A serial line bit arrives each time `line_en` is high. The block hunts for the 10-bit frame alignment word and confirms it over several frames before it declares frame lock. Once locked, it steers each line bit to one of four tributaries by the bit's place in the 848-bit frame. It also removes the frame overhead: the alignment word, the alarm and spare bits, and the justification control bits.

Each tributary has one justification opportunity per frame. Three control bits for that tributary are spread across the frame, and a majority vote over them decides whether the opportunity carries a stuff bit. A stuff bit gets no write strobe, so the tributary sees a gapped stream that keeps its bit order. The output for each tributary is a data bit with a write enable. Clock smoothing for that stream is done outside this block.

Top module: `e2_demux_destuff`

## Requirements
- R1: While reset is asserted, and afterwards until lock, `frame_locked` and `alarm_out` are 0. Outside lock, `trib_we` is all zero.
- R2: Frame positions are counted 0 to 847 in arrival order, and the alignment word 1111010000 occupies positions 0..9, sent MSB first. From search, a match sets the next bit to position 10. Two more matches at positions 0..9 of the following frames raise `frame_locked` one clock after the `line_en` that carried the third word's last bit.
- R3: While lock is being confirmed, a single frame whose word does not match sends the block back to search. Lock then needs three fresh consecutive matches.
- R4: Once locked, lock falls after 4 consecutive frames without a match. A match after fewer misses clears the miss count.
- R5: While locked, a payload bit at position p (p ≥ 12) goes to tributary p mod 4. It appears on `trib_data[p mod 4]` with `trib_we[p mod 4]` high for exactly one clock, one clock after its `line_en` cycle. At most one strobe is high at a time.
- R6: Positions 0..11 are never written to any tributary. Neither are the control slots 212+k, 424+k and 636+k of tributary k.
- R7: The justification slot of tributary k is position 640+k. It is dropped when at least 2 of that frame's three control bits for k are 1, and written as data otherwise. With no other errors, a fully locked frame gives 205 writes per tributary when a stuff bit is signalled and 206 when it is not.
- R8: `alarm_out` takes the bit at position 10 of each frame received while locked. While unlocked it holds its value.
- R9: No tributary write strobe is produced while the block is not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_en | input | 1 | A line bit is present this cycle |
| line_bit | input | 1 | Serial line bit |
| frame_locked | output | 1 | Frame alignment is established |
| alarm_out | output | 1 | Last alarm bit received while locked |
| trib_we | output | 4 | Per-tributary write strobe |
| trib_data | output | 4 | Per-tributary data bit, valid with its strobe |

## Verification
The hardest conditions to reach are a lock that survives three missing words but falls on the fourth, and a confirmation that is broken part way through. The stimulus builds whole frames in which the alignment word can be corrupted frame by frame. Payload bits are shaped so that no run of four ones can form a false alignment word anywhere else. The frame series can therefore step the framer through exact hit and miss counts. Control bits with one corrupted copy in each direction exercise the majority vote, and each tributary's per-frame write count is checked against 205 or 206.

// File: rtl/e2dd_pkg.sv
package e2dd_pkg;
  typedef enum logic [1:0] {
    FR_SEARCH  = 2'd0,
    FR_CONFIRM = 2'd1,
    FR_LOCK    = 2'd2
  } fr_state_t;
endpackage

// File: rtl/e2dd_framer.sv
module e2dd_framer
  import e2dd_pkg::*;
#(
  parameter int FRAME_BITS   = 848,
  parameter int ALIGN_LEN    = 10,
  parameter logic [ALIGN_LEN-1:0] ALIGN_WORD = 10'b1111010000,
  parameter int CONFIRM_HITS = 3,
  parameter int LOSS_MISSES  = 4,
  parameter int POS_W        = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic             locked,
  output logic [POS_W-1:0] pos,
  output logic             alarm
);
  localparam int HIT_W   = $clog2(CONFIRM_HITS + 1);
  localparam int MISS_W  = $clog2(LOSS_MISSES + 1);
  localparam int ALARM_P = ALIGN_LEN;

  fr_state_t              state_q, state_d;
  logic [POS_W-1:0]       pos_q, pos_d;
  logic [ALIGN_LEN-2:0]   hist_q, hist_d;
  logic [HIT_W-1:0]       hit_q, hit_d;
  logic [MISS_W-1:0]      miss_q, miss_d;
  logic                   alarm_q, alarm_d;
  logic [ALIGN_LEN-1:0]   window;
  logic                   match, at_check;

  assign window   = {hist_q, bit_in};
  assign match    = (window == ALIGN_WORD);
  assign at_check = (pos_q == POS_W'(ALIGN_LEN - 1));

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    hist_d  = hist_q;
    hit_d   = hit_q;
    miss_d  = miss_q;
    alarm_d = alarm_q;
    if (bit_en) begin
      hist_d = window[ALIGN_LEN-2:0];
      pos_d  = (pos_q == POS_W'(FRAME_BITS - 1)) ? '0 : pos_q + POS_W'(1);
      unique case (state_q)
        FR_SEARCH: begin
          if (match) begin
            state_d = FR_CONFIRM;
            hit_d   = HIT_W'(1);
            pos_d   = POS_W'(ALIGN_LEN);
          end
        end
        FR_CONFIRM: begin
          if (at_check) begin
            if (!match) begin
              state_d = FR_SEARCH;
            end else if (hit_q == HIT_W'(CONFIRM_HITS - 1)) begin
              state_d = FR_LOCK;
              miss_d  = '0;
            end else begin
              hit_d = hit_q + HIT_W'(1);
            end
          end
        end
        FR_LOCK: begin
          if (pos_q == POS_W'(ALARM_P)) alarm_d = bit_in;
          if (at_check) begin
            if (match) begin
              miss_d = '0;
            end else if (miss_q == MISS_W'(LOSS_MISSES - 1)) begin
              state_d = FR_SEARCH;
            end else begin
              miss_d = miss_q + MISS_W'(1);
            end
          end
        end
        default: state_d = FR_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_SEARCH;
      pos_q   <= '0;
      hist_q  <= '0;
      hit_q   <= '0;
      miss_q  <= '0;
      alarm_q <= 1'b0;
    end else if (bit_en) begin
      state_q <= state_d;
      pos_q   <= pos_d;
      hist_q  <= hist_d;
      hit_q   <= hit_d;
      miss_q  <= miss_d;
      alarm_q <= alarm_d;
    end
  end

  assign locked = (state_q == FR_LOCK);
  assign pos    = pos_q;
  assign alarm  = alarm_q;
endmodule

// File: rtl/e2dd_lane.sv
module e2dd_lane #(
  parameter int K           = 0,
  parameter int NUM_TRIB    = 4,
  parameter int GROUP_BITS  = 212,
  parameter int HDR_BITS    = 12,
  parameter int CTRL_COPIES = 3,
  parameter int POS_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic [POS_W-1:0] pos,
  output logic             wr_en,
  output logic             wr_data
);
  localparam int CNT_W     = $clog2(CTRL_COPIES + 1);
  localparam int JUST_SLOT = CTRL_COPIES * GROUP_BITS + NUM_TRIB + K;

  logic [CTRL_COPIES-1:0] is_ctrl, ctrl_q, ctrl_d;
  logic [CNT_W-1:0]       ones;
  logic                   lane_sel, just_slot, stuff, payload;
  logic                   wr_en_q, wr_data_q, wr_data_d;

  for (genvar g = 0; g < CTRL_COPIES; g++) begin : g_ctrl
    assign is_ctrl[g] = (pos == POS_W'((g + 1) * GROUP_BITS + K));
    assign ctrl_d[g]  = (bit_en && is_ctrl[g]) ? bit_in : ctrl_q[g];
  end

  always_comb begin
    ones = '0;
    for (int g = 0; g < CTRL_COPIES; g++) ones = ones + CNT_W'(ctrl_q[g]);
  end

  assign stuff     = (ones > CNT_W'(CTRL_COPIES / 2));
  assign lane_sel  = ((pos % POS_W'(NUM_TRIB)) == POS_W'(K));
  assign just_slot = (pos == POS_W'(JUST_SLOT));
  assign payload   = bit_en && lane_sel && (pos >= POS_W'(HDR_BITS))
                     && (is_ctrl == '0) && !(just_slot && stuff);
  assign wr_data_d = payload ? bit_in : wr_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_data_q <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      wr_en_q   <= payload;
      wr_data_q <= wr_data_d;
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_data = wr_data_q;
endmodule

// File: rtl/e2_demux_destuff.sv
module e2_demux_destuff #(
  parameter int FRAME_BITS   = 848,
  parameter int NUM_TRIB     = 4,
  parameter int ALIGN_LEN    = 10,
  parameter logic [ALIGN_LEN-1:0] ALIGN_WORD = 10'b1111010000,
  parameter int CONFIRM_HITS = 3,
  parameter int LOSS_MISSES  = 4,
  parameter int CTRL_COPIES  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_en,
  input  logic                line_bit,
  output logic                frame_locked,
  output logic                alarm_out,
  output logic [NUM_TRIB-1:0] trib_we,
  output logic [NUM_TRIB-1:0] trib_data
);
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int GROUP_BITS = FRAME_BITS / NUM_TRIB;
  localparam int HDR_BITS   = ALIGN_LEN + 2;

  logic [POS_W-1:0] pos_w;
  logic             locked_w;
  logic             lane_en;

  e2dd_framer #(
    .FRAME_BITS  (FRAME_BITS),
    .ALIGN_LEN   (ALIGN_LEN),
    .ALIGN_WORD  (ALIGN_WORD),
    .CONFIRM_HITS(CONFIRM_HITS),
    .LOSS_MISSES (LOSS_MISSES),
    .POS_W       (POS_W)
  ) u_framer (
    .clk   (clk),
    .rst_n (rst_n),
    .bit_en(line_en),
    .bit_in(line_bit),
    .locked(locked_w),
    .pos   (pos_w),
    .alarm (alarm_out)
  );

  assign lane_en = line_en & locked_w;

  for (genvar k = 0; k < NUM_TRIB; k++) begin : g_lane
    e2dd_lane #(
      .K          (k),
      .NUM_TRIB   (NUM_TRIB),
      .GROUP_BITS (GROUP_BITS),
      .HDR_BITS   (HDR_BITS),
      .CTRL_COPIES(CTRL_COPIES),
      .POS_W      (POS_W)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (lane_en),
      .bit_in (line_bit),
      .pos    (pos_w),
      .wr_en  (trib_we[k]),
      .wr_data(trib_data[k])
    );
  end

  assign frame_locked = locked_w;
endmodule

// File: rtl/e2dd_checker.sv
module e2dd_checker #(
  parameter int NUM_TRIB   = 4,
  parameter int FRAME_BITS = 848,
  parameter int POS_W      = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                line_en,
  input logic                frame_locked,
  input logic                alarm_out,
  input logic [NUM_TRIB-1:0] trib_we,
  input logic [POS_W-1:0]    pos
);
  assert_we_only_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trib_we != '0) |-> $past(frame_locked));

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trib_we));

  assert_we_after_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trib_we != '0) |-> $past(line_en));

  assert_alarm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_locked |=> $stable(alarm_out));

  assert_lock_on_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en |=> $stable(frame_locked));

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos < POS_W'(FRAME_BITS));
endmodule

bind e2_demux_destuff e2dd_checker #(
  .NUM_TRIB  (NUM_TRIB),
  .FRAME_BITS(FRAME_BITS),
  .POS_W     (POS_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_en     (line_en),
  .frame_locked(frame_locked),
  .alarm_out   (alarm_out),
  .trib_we     (trib_we),
  .pos         (pos_w)
);

// File: tb/e2_demux_destuff_bench.sv
module e2_demux_destuff_bench;
  logic       clk;
  logic       rst_n;
  logic       line_en;
  logic       line_bit;
  logic       frame_locked;
  logic       alarm_out;
  logic [3:0] trib_we;
  logic [3:0] trib_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  e2_demux_destuff u_e2_demux_destuff (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .line_bit(line_bit),
    .frame_locked(frame_locked), .alarm_out(alarm_out),
    .trib_we(trib_we), .trib_data(trib_data)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_state;      // 0 search, 1 confirm, 2 locked
  int m_pos, m_win, m_hits, m_miss;
  int m_ctrl[4][3];
  bit exp_locked, exp_alarm;
  bit [3:0] exp_we, exp_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_pos = 0; m_win = 0; m_hits = 0; m_miss = 0;
      for (int k = 0; k < 4; k++) for (int g = 0; g < 3; g++) m_ctrl[k][g] = 0;
      exp_locked = 0; exp_alarm = 0; exp_we = 0; exp_data = 0;
    end else begin
      exp_we = 0;
      if (line_en) begin
        m_win = ((m_win << 1) | int'(line_bit)) & 1023;
        if (m_state == 2) begin
          if (m_pos == 10) exp_alarm = line_bit;
          if (m_pos >= 12) begin
            int k, votes;
            bit wr;
            k = m_pos % 4;
            wr = 1;
            for (int g = 0; g < 3; g++)
              if (m_pos == (g + 1) * 212 + k) begin m_ctrl[k][g] = line_bit; wr = 0; end
            if (m_pos == 640 + k) begin
              votes = m_ctrl[k][0] + m_ctrl[k][1] + m_ctrl[k][2];
              if (votes >= 2) wr = 0;
            end
            if (wr) begin exp_we[k] = 1; exp_data[k] = line_bit; end
          end
        end
        if (m_state == 0) begin
          m_pos = (m_pos + 1) % 848;
          if (m_win == 'h3D0) begin m_state = 1; m_hits = 1; m_pos = 10; end
        end else begin
          bit hit;
          hit = (m_win == 'h3D0);
          if (m_pos == 9) begin
            if (m_state == 1) begin
              if (!hit) m_state = 0;
              else begin m_hits++; if (m_hits == 3) begin m_state = 2; m_miss = 0; end end
            end else begin
              if (hit) m_miss = 0;
              else begin m_miss++; if (m_miss == 4) m_state = 0; end
            end
          end
          m_pos = (m_pos + 1) % 848;
        end
      end
      exp_locked = (m_state == 2);
    end
  end

  // cycle compare, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    check(frame_locked == exp_locked, "R2/R3/R4 lock state", frame_locked, exp_locked);
    check(alarm_out == exp_alarm, "R8 alarm", alarm_out, exp_alarm);
    check(trib_we == exp_we, "R5/R6/R7/R9 write strobes", trib_we, exp_we);
    check((trib_data & exp_we) == (exp_data & exp_we), "R5 tributary data",
          trib_data & exp_we, exp_data & exp_we);
  end

  int we_cnt[4];
  always @(negedge clk) for (int k = 0; k < 4; k++) if (trib_we[k]) we_cnt[k]++;

  // ---------------- stimulus ----------------
  bit fr[848];
  int lfsr = 'h1ACE;
  int gap  = 0;

  function automatic int vote3(input bit [2:0] c);
    return int'(c[0]) + int'(c[1]) + int'(c[2]);
  endfunction

  task automatic send_frame(input bit good, input bit alarm,
                            input bit [2:0] c0, input bit [2:0] c1,
                            input bit [2:0] c2, input bit [2:0] c3);
    bit [2:0] cs[4];
    bit [9:0] word;
    cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3;
    word = 10'b1111010000;
    if (!good) word[9] = 1'b0;
    for (int p = 0; p < 848; p++) begin
      int k;
      k = p % 4;
      if (p < 10) fr[p] = word[9 - p];
      else if (p == 10) fr[p] = alarm;
      else if (p == 11) fr[p] = 1'b0;
      else if (p == 212 + k) fr[p] = cs[k][2];
      else if (p == 424 + k) fr[p] = cs[k][1];
      else if (p == 636 + k) fr[p] = cs[k][0];
      else if (p == 640 + k && vote3(cs[k]) >= 2) fr[p] = 1'b0;
      else begin
        lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hFFFF;
        fr[p] = lfsr[0];
        if (fr[p-1] && fr[p-2] && fr[p-3]) fr[p] = 1'b0;  // no false alignment word
      end
    end
    for (int k = 0; k < 4; k++) we_cnt[k] = 0;
    for (int p = 0; p < 848; p++) begin
      gap++;
      if (gap % 9 == 8) begin @(negedge clk); line_en = 0; end
      @(negedge clk); line_en = 1; line_bit = fr[p];
    end
    @(negedge clk); line_en = 0;
    @(negedge clk); #1;
  endtask

  task automatic good_frame();
    send_frame(1, 0, 3'b000, 3'b000, 3'b000, 3'b000);
  endtask

  task automatic bad_frame();
    send_frame(0, 0, 3'b000, 3'b000, 3'b000, 3'b000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 0; line_en = 0; line_bit = 0;
    repeat (3) @(negedge clk);
    #1;
    check(frame_locked == 0, "R1 reset locked", frame_locked, 0);
    check(alarm_out == 0, "R1 reset alarm", alarm_out, 0);
    check(trib_we == 0, "R1 reset strobes", trib_we, 0);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 23; i++) begin @(negedge clk); line_en = 1; line_bit = 0; end
    @(negedge clk); line_en = 0;

    // R2: three aligned words give lock
    good_frame(); good_frame();
    check(frame_locked == 0, "R2 not locked after two words", frame_locked, 0);
    good_frame();
    check(frame_locked == 1, "R2 locked after three words", frame_locked, 1);

    // R7 vote, R6 overhead not written, R8 alarm
    send_frame(1, 1, 3'b111, 3'b000, 3'b110, 3'b001);
    check(we_cnt[0] == 205, "R7 trib0 ctrl 111", we_cnt[0], 205);
    check(we_cnt[1] == 206, "R7 trib1 ctrl 000", we_cnt[1], 206);
    check(we_cnt[2] == 205, "R7 trib2 ctrl 110", we_cnt[2], 205);
    check(we_cnt[3] == 206, "R7 trib3 ctrl 001", we_cnt[3], 206);
    check(alarm_out == 1, "R8 alarm captured", alarm_out, 1);
    send_frame(1, 0, 3'b011, 3'b101, 3'b000, 3'b111);
    check(we_cnt[0] == 205, "R7 trib0 ctrl 011", we_cnt[0], 205);
    check(we_cnt[1] == 205, "R7 trib1 ctrl 101", we_cnt[1], 205);
    check(we_cnt[2] == 206, "R7 trib2 ctrl 000", we_cnt[2], 206);
    check(we_cnt[3] == 205, "R7 trib3 ctrl 111", we_cnt[3], 205);
    check(alarm_out == 0, "R8 alarm cleared", alarm_out, 0);

    // R4: three misses tolerated
    bad_frame(); bad_frame(); bad_frame();
    check(we_cnt[1] == 206, "R6 writes continue through misses", we_cnt[1], 206);
    good_frame();
    check(frame_locked == 1, "R4 lock kept after three misses", frame_locked, 1);

    // R4: four misses lose lock
    bad_frame(); bad_frame(); bad_frame(); bad_frame();
    check(frame_locked == 0, "R4 lock lost after four misses", frame_locked, 0);
    send_frame(0, 1, 3'b000, 3'b000, 3'b000, 3'b000);
    check(we_cnt[0] + we_cnt[1] + we_cnt[2] + we_cnt[3] == 0, "R9 no writes unlocked",
          we_cnt[0] + we_cnt[1] + we_cnt[2] + we_cnt[3], 0);
    check(alarm_out == 0, "R8 alarm held unlocked", alarm_out, 0);

    // R3: a broken confirmation restarts the count
    good_frame(); bad_frame(); good_frame(); good_frame();
    check(frame_locked == 0, "R3 no lock after broken confirm", frame_locked, 0);
    good_frame();
    check(frame_locked == 1, "R3 lock after three fresh words", frame_locked, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule